// File: doc/BRIEF.md
# Stuck-Cell Tolerant Line Writer with Per-Partition Inversion

This block sits between a requester and a resistive line store whose cells can wear out and stay stuck at 0 or at 1. A stuck cell can still be read, so the block does not route around it. It makes the stuck cell's value part of the stored code. A line of `LINE_W` bits is cut into `NPART` equal contiguous partitions. Each partition is written either as it is or fully inverted, and one flag bit per partition records which choice was made. The flags are stored beside the line.

Every write is followed by a read-back of the line. If a bit did not take its intended value, the block notes the position and the value read there in a small fault cache. The cache is keyed by line address. The block then writes the line again with flags recomputed from the cache. Faults that are already cached are honoured on the first try, so a line with known faults does not cost extra write cycles. A read returns the line with every flagged partition inverted back.

The store is expected to have one-cycle read latency: data requested with `mem_re` appears on `mem_rdata` and `mem_rflags` after the next rising edge.

Top module: `stuck_part_ctrl`

## Requirements
- R1: While reset is held and right after it, `busy`, `wr_done`, `wr_fail`, `rd_valid`, `mem_we` and `mem_re` are all low, and the fault cache is empty.
- R2: Partition p covers bits [p*PART_W +: PART_W], where PART_W = LINE_W/NPART. Flag p is driven on `mem_wflags[p]`. Flag p is 1 exactly when the cache holds a fault for the current address inside partition p and the request data bit at that position differs from the cached stuck value. `mem_wdata` equals the request data XOR each flag replicated across its partition.
- R3: An accepted write runs in attempts. Each attempt is one cycle of `mem_we`, then one cycle of `mem_re`, then one compare cycle. If the first attempt reads back clean, `wr_done` is high, with `wr_fail` low, for one cycle after the third rising edge following the accepting edge. Each further attempt adds three edges.
- R4: If the read-back differs from what was written, the block records the lowest mismatching bit position and the value read there in the cache. It then rewrites the line, and the rewrite stores the intended data.
- R5: A write to an address whose stuck cells are all in the cache finishes after a single attempt.
- R6: At most MAX_RETRY (default 2) rewrites follow the first attempt. If the last attempt still mismatches, `wr_done` and `wr_fail` are raised together.
- R7: Two mismatching bits in one partition, or a mismatch in a partition that already holds a cached fault for that address, ends the write at once with `wr_fail`. Nothing is inserted into the cache in that case.
- R8: The cache holds CACHE_DEPTH (default 4) entries. A new entry overwrites the entry that was inserted longest ago.
- R9: A read raises `rd_valid` for one cycle after the second rising edge following the accepting edge. `rd_data` is `mem_rdata` XOR each `mem_rflags` bit replicated across its partition.
- R10: Requests are accepted only while `busy` is low. If `req_wr` and `req_rd` are high together, the write is taken. Requests made while busy are ignored.
- R11: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | Write request, sampled while idle |
| req_rd | input | 1 | Read request, sampled while idle |
| req_addr | input | ADDR_W | Line address of the request |
| req_data | input | LINE_W | Data to write |
| busy | output | 1 | A request is in progress |
| wr_done | output | 1 | One-cycle pulse when a write ends |
| wr_fail | output | 1 | High with `wr_done` when the write could not be stored |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is fresh |
| rd_data | output | LINE_W | Read data with inversions removed |
| mem_we | output | 1 | Store write strobe |
| mem_re | output | 1 | Store read strobe |
| mem_addr | output | ADDR_W | Store line address |
| mem_wdata | output | LINE_W | Encoded line to store |
| mem_wflags | output | NPART | Inversion flags to store |
| mem_rdata | input | LINE_W | Stored line, one cycle after `mem_re` |
| mem_rflags | input | NPART | Stored flags, one cycle after `mem_re` |

## Verification
A write result is due 3·n rising edges after the accepting edge, where n is the number of attempts. A read result is due two edges after its accepting edge. Before each request, the bench predicts n, the fail outcome and the final flags from its own model of the stuck cells and of the oldest-first fault cache. From the accepting edge on, it samples every falling edge and compares `busy`, `wr_done`, `wr_fail` and `rd_valid` against the edge count. The captured last `mem_wflags`/`mem_wdata` and the returned `rd_data` are checked once the request has finished.

// File: rtl/sfp_pkg.sv
`timescale 1ns/1ps
package sfp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR,
      ST_VRD,
      ST_VCHK,
      ST_RD,
      ST_RCAP
   } ctl_state_t;
endpackage

// File: rtl/sfp_flag_expand.sv
`timescale 1ns/1ps
// Replicates one flag per partition across that partition's bits.
module sfp_flag_expand #(
   parameter int LINE_W = 512,
   parameter int NPART  = 8
) (
   input  logic [NPART-1:0]  flags,
   output logic [LINE_W-1:0] mask
);
   localparam int PART_W = LINE_W / NPART;

   for (genvar p = 0; p < NPART; p++) begin : g_part
      assign mask[p*PART_W +: PART_W] = {PART_W{flags[p]}};
   end
endmodule

// File: rtl/sfp_verify_scan.sv
`timescale 1ns/1ps
// Compares read-back with the written line, per partition.
module sfp_verify_scan #(
   parameter int LINE_W = 512,
   parameter int NPART  = 8
) (
   input  logic [LINE_W-1:0]        got,
   input  logic [LINE_W-1:0]        want,
   output logic                     any_err,
   output logic [NPART-1:0]         part_err,
   output logic [NPART-1:0]         part_multi,
   output logic [$clog2(LINE_W)-1:0] first_pos
);
   localparam int PART_W = LINE_W / NPART;
   localparam int POS_W  = $clog2(LINE_W);
   localparam int OFF_W  = $clog2(PART_W);
   localparam int PIDX_W = POS_W - OFF_W;

   logic [LINE_W-1:0]             diff;
   logic [NPART-1:0][OFF_W-1:0]   part_off;

   assign diff = got ^ want;

   for (genvar p = 0; p < NPART; p++) begin : g_part
      logic [PART_W-1:0] slice;
      assign slice         = diff[p*PART_W +: PART_W];
      assign part_err[p]   = |slice;
      assign part_multi[p] = ($countones(slice) > 1);
      always_comb begin
         part_off[p] = '0;
         for (int i = PART_W - 1; i >= 0; i--) begin
            if (slice[i]) part_off[p] = OFF_W'(i);
         end
      end
   end

   assign any_err = |part_err;

   always_comb begin
      first_pos = '0;
      for (int p = NPART - 1; p >= 0; p--) begin
         if (part_err[p]) first_pos = {PIDX_W'(p), part_off[p]};
      end
   end
endmodule

// File: rtl/sfp_fault_cache.sv
`timescale 1ns/1ps
// Small table of known stuck cells, replaced oldest-inserted first.
module sfp_fault_cache #(
   parameter int LINE_W = 512,
   parameter int NPART  = 8,
   parameter int ADDR_W = 4,
   parameter int DEPTH  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 lk_addr,
   input  logic [LINE_W-1:0]                 lk_data,
   input  logic                              ins_en,
   input  logic [$clog2(LINE_W)-1:0]         ins_pos,
   input  logic                              ins_val,
   output logic [NPART-1:0]                  part_hit,
   output logic [NPART-1:0][$clog2(LINE_W)-1:0] part_pos,
   output logic [NPART-1:0]                  part_val,
   output logic [NPART-1:0]                  part_flag
);
   localparam int PART_W = LINE_W / NPART;
   localparam int POS_W  = $clog2(LINE_W);
   localparam int OFF_W  = $clog2(PART_W);
   localparam int PIDX_W = POS_W - OFF_W;
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0]  vld;
   logic [ADDR_W-1:0] tag   [DEPTH];
   logic [POS_W-1:0]  epos  [DEPTH];
   logic              esv   [DEPTH];
   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  ptr_nx;

   // Pointer wrap: free for a power-of-two depth, explicit compare otherwise.
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign ptr_nx = ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nx = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         ptr <= '0;
      end else if (ins_en) begin
         vld[ptr] <= 1'b1;
         ptr      <= ptr_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en) begin
         tag[ptr]  <= lk_addr;
         epos[ptr] <= ins_pos;
         esv[ptr]  <= ins_val;
      end
   end

   always_comb begin
      for (int p = 0; p < NPART; p++) begin
         part_hit[p] = 1'b0;
         part_pos[p] = '0;
         part_val[p] = 1'b0;
         for (int e = 0; e < DEPTH; e++) begin
            if (!part_hit[p] && vld[e] && tag[e] == lk_addr &&
                epos[e][POS_W-1:OFF_W] == PIDX_W'(p)) begin
               part_hit[p] = 1'b1;
               part_pos[p] = epos[e];
               part_val[p] = esv[e];
            end
         end
         part_flag[p] = part_hit[p] & (lk_data[part_pos[p]] ^ part_val[p]);
      end
   end

   // R7: the controller never adds a second fault to a partition already holding one
   ins_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !part_hit[ins_pos[POS_W-1:OFF_W]]);
endmodule

// File: rtl/stuck_part_ctrl.sv
`timescale 1ns/1ps
module stuck_part_ctrl
   import sfp_pkg::*;
#(
   parameter int LINE_W      = 512,
   parameter int NPART       = 8,
   parameter int ADDR_W      = 4,
   parameter int CACHE_DEPTH = 4,
   parameter int MAX_RETRY   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic              req_rd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LINE_W-1:0] req_data,
   output logic              busy,
   output logic              wr_done,
   output logic              wr_fail,
   output logic              rd_valid,
   output logic [LINE_W-1:0] rd_data,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   output logic [NPART-1:0]  mem_wflags,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic [NPART-1:0]  mem_rflags
);
   localparam int PART_W = LINE_W / NPART;
   localparam int POS_W  = $clog2(LINE_W);
   localparam int RCNT_W = $clog2(MAX_RETRY + 2);

   // Elaboration-time parameter checks
   if (NPART < 2 || (NPART & (NPART - 1)) != 0) begin : g_bad_npart
      $error("NPART must be a power of two, at least 2");
   end
   if (LINE_W % NPART != 0 || (PART_W & (PART_W - 1)) != 0) begin : g_bad_line
      $error("LINE_W/NPART must be a whole power of two");
   end
   if (CACHE_DEPTH < 1 || ADDR_W < 1 || MAX_RETRY < 0) begin : g_bad_misc
      $error("CACHE_DEPTH and ADDR_W must be positive, MAX_RETRY non-negative");
   end

   ctl_state_t              state;
   logic [ADDR_W-1:0]       addr_q;
   logic [LINE_W-1:0]       data_q;
   logic [LINE_W-1:0]       exp_q;
   logic [RCNT_W-1:0]       retry_q;
   logic                    done_q, fail_q, rdv_q;
   logic [LINE_W-1:0]       rdat_q;

   logic [NPART-1:0]              c_hit, c_val, c_flag;
   logic [NPART-1:0][POS_W-1:0]   c_pos;
   logic [LINE_W-1:0]             wmask, rmask;
   logic                          s_any;
   logic [NPART-1:0]              s_err, s_multi;
   logic [POS_W-1:0]              s_first;
   logic                          conflict, in_chk, ins_en;

   sfp_fault_cache #(
      .LINE_W(LINE_W), .NPART(NPART), .ADDR_W(ADDR_W), .DEPTH(CACHE_DEPTH)
   ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_addr   (addr_q),
      .lk_data   (data_q),
      .ins_en    (ins_en),
      .ins_pos   (s_first),
      .ins_val   (mem_rdata[s_first]),
      .part_hit  (c_hit),
      .part_pos  (c_pos),
      .part_val  (c_val),
      .part_flag (c_flag)
   );

   sfp_flag_expand #(.LINE_W(LINE_W), .NPART(NPART)) u_wexp (
      .flags (c_flag),
      .mask  (wmask)
   );

   sfp_flag_expand #(.LINE_W(LINE_W), .NPART(NPART)) u_rexp (
      .flags (mem_rflags),
      .mask  (rmask)
   );

   sfp_verify_scan #(.LINE_W(LINE_W), .NPART(NPART)) u_scan (
      .got        (mem_rdata),
      .want       (exp_q),
      .any_err    (s_any),
      .part_err   (s_err),
      .part_multi (s_multi),
      .first_pos  (s_first)
   );

   assign in_chk   = (state == ST_VCHK);
   assign conflict = |s_multi || |(s_err & c_hit);
   assign ins_en   = in_chk && s_any && !conflict &&
                     (retry_q < RCNT_W'(MAX_RETRY));

   assign mem_we     = (state == ST_WR);
   assign mem_re     = (state == ST_VRD) || (state == ST_RD);
   assign mem_addr   = addr_q;
   assign mem_wdata  = data_q ^ wmask;
   assign mem_wflags = c_flag;

   assign busy     = (state != ST_IDLE);
   assign wr_done  = done_q;
   assign wr_fail  = fail_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdat_q;

   // Control path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         retry_q <= '0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         rdv_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         rdv_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_wr) begin
                  retry_q <= '0;
                  state   <= ST_WR;
               end else if (req_rd) begin
                  state <= ST_RD;
               end
            end
            ST_WR:   state <= ST_VRD;
            ST_VRD:  state <= ST_VCHK;
            ST_VCHK: begin
               if (!s_any) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (ins_en) begin
                  retry_q <= retry_q + 1'b1;
                  state   <= ST_WR;
               end else begin
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_RD:   state <= ST_RCAP;
            ST_RCAP: begin
               rdv_q <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Data path registers
   always_ff @(posedge clk) begin
      if (state == ST_IDLE && (req_wr || req_rd)) addr_q <= req_addr;
      if (state == ST_IDLE && req_wr)             data_q <= req_data;
      if (state == ST_WR)                         exp_q  <= mem_wdata;
      if (state == ST_RCAP)                       rdat_q <= mem_rdata ^ rmask;
   end

   // R11
   mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R6
   retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_q <= RCNT_W'(MAX_RETRY));

   // R6
   fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fail |-> wr_done);

   // R9
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(mem_re, 2));

   // R4
   first_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_chk && s_any) |-> (mem_rdata[s_first] != exp_q[s_first]));

   // R2: every cached stuck cell is written with its stuck value
   for (genvar p = 0; p < NPART; p++) begin : g_honour
      stuck_honour_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_we && c_hit[p]) |-> (mem_wdata[c_pos[p]] == c_val[p]));
   end
endmodule

// File: tb/stuck_part_ctrl_bench.sv
`timescale 1ns/1ps
module stuck_part_ctrl_bench;
   localparam int LW = 512;
   localparam int NP = 8;
   localparam int PW = LW / NP;
   localparam int AW = 4;
   localparam int NA = 1 << AW;
   localparam int CD = 4;
   localparam int MR = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_wr = 1'b0, req_rd = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_data = '0;
   logic          busy, wr_done, wr_fail, rd_valid;
   logic [LW-1:0] rd_data;
   logic          mem_we, mem_re;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata;
   logic [NP-1:0] mem_wflags;
   logic [LW-1:0] mem_rdata = '0;
   logic [NP-1:0] mem_rflags = '0;

   always #2.5 clk = ~clk;

   stuck_part_ctrl #(.LINE_W(LW), .NPART(NP), .ADDR_W(AW),
                     .CACHE_DEPTH(CD), .MAX_RETRY(MR)) u_stuck_part_ctrl (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
      .req_addr(req_addr), .req_data(req_data), .busy(busy),
      .wr_done(wr_done), .wr_fail(wr_fail), .rd_valid(rd_valid),
      .rd_data(rd_data), .mem_we(mem_we), .mem_re(mem_re),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wflags(mem_wflags),
      .mem_rdata(mem_rdata), .mem_rflags(mem_rflags)
   );

   // Store with stuck cells, one-cycle read latency
   logic [LW-1:0] mline [NA];
   logic [NP-1:0] mflg  [NA];
   logic [LW-1:0] smask [NA];
   logic [LW-1:0] sval  [NA];
   logic [LW-1:0] exp_line [NA];
   logic [LW-1:0] cap_wdata = '0;
   logic [NP-1:0] cap_wflags = '0;
   int            excl_bad = 0;

   always @(posedge clk) begin
      if (mem_we) begin
         mline[mem_addr] <= (mem_wdata & ~smask[mem_addr]) | (sval[mem_addr] & smask[mem_addr]);
         mflg[mem_addr]  <= mem_wflags;
         cap_wdata       <= mem_wdata;
         cap_wflags      <= mem_wflags;
      end
      if (mem_re) begin
         mem_rdata  <= mline[mem_addr];
         mem_rflags <= mflg[mem_addr];
      end
      if (mem_we && mem_re) excl_bad <= excl_bad + 1;
   end

   // Reference fault cache, oldest-inserted replaced first
   bit cv [CD];
   int ca [CD];
   int cp [CD];
   bit cs [CD];
   int cptr = 0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   function automatic logic [LW-1:0] rep(input logic [NP-1:0] f);
      logic [LW-1:0] m;
      for (int p = 0; p < NP; p++) m[p*PW +: PW] = {PW{f[p]}};
      return m;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_write(input int a, input logic [LW-1:0] d,
                              output int att, output bit fl, output logic [NP-1:0] fg);
      int retries = 0;
      att = 0;
      fl  = 0;
      fg  = '0;
      for (int it = 0; it < MR + 1; it++) begin
         logic [LW-1:0] stored, actual, diff;
         bit hitp [NP];
         bit conflict = 0;
         att++;
         fg = '0;
         for (int p = 0; p < NP; p++) begin
            hitp[p] = 0;
            for (int e = 0; e < CD; e++)
               if (!hitp[p] && cv[e] && ca[e] == a && cp[e] / PW == p) begin
                  hitp[p] = 1;
                  fg[p] = d[cp[e]] ^ cs[e];
               end
         end
         stored = d ^ rep(fg);
         actual = (stored & ~smask[a]) | (sval[a] & smask[a]);
         diff   = actual ^ stored;
         if (diff == '0) break;
         for (int p = 0; p < NP; p++) begin
            int n = $countones(diff[p*PW +: PW]);
            if (n > 1 || (n > 0 && hitp[p])) conflict = 1;
         end
         if (conflict || retries == MR) begin
            fl = 1;
            break;
         end
         for (int i = LW - 1; i >= 0; i--)
            if (diff[i]) begin
               cp[cptr] = i;
               cs[cptr] = actual[i];
            end
         cv[cptr] = 1;
         ca[cptr] = a;
         cptr = (cptr + 1) % CD;
         retries++;
      end
   endtask

   task automatic do_write(input int a, input logic [LW-1:0] d, input bit both,
                           input bit poke, input string req);
      int att, w;
      bit fl;
      logic [NP-1:0] fg;
      model_write(a, d, att, fl, fg);
      w = 3 * att;
      @(negedge clk);
      req_addr = AW'(a); req_data = d; req_wr = 1'b1; req_rd = both;
      @(negedge clk);
      req_wr = 1'b0; req_rd = 1'b0;
      chk(busy == 1'b1, "R10", "busy after accept", LW'(busy), LW'(1));
      for (int k = 1; k <= w + 3; k++) begin
         @(negedge clk);
         if (poke && k == 1) begin
            req_wr = 1'b1; req_rd = 1'b1; req_addr = AW'(7);
         end else begin
            req_wr = 1'b0; req_rd = 1'b0;
         end
         chk(wr_done == (k == w), req, "wr_done timing", LW'(wr_done), LW'(k == w));
         chk(wr_fail == (k == w && fl), req, "wr_fail", LW'(wr_fail), LW'(k == w && fl));
         chk(busy == (k < w), poke ? "R10" : req, "busy", LW'(busy), LW'(k < w));
         chk(rd_valid == 1'b0, "R10", "no read during write", LW'(rd_valid), LW'(0));
      end
      // R2: flags and encoded data of the last attempt
      chk(cap_wflags == fg, "R2", "mem_wflags", LW'(cap_wflags), LW'(fg));
      chk(cap_wdata == (d ^ rep(fg)), "R2", "mem_wdata", cap_wdata, d ^ rep(fg));
      if (!fl) exp_line[a] = d;
   endtask

   task automatic do_read(input int a);
      @(negedge clk);
      req_addr = AW'(a); req_rd = 1'b1;
      @(negedge clk);
      req_rd = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk(rd_valid == (k == 2), "R9", "rd_valid timing", LW'(rd_valid), LW'(k == 2));
         if (k == 2) chk(rd_data == exp_line[a], "R9", "rd_data", rd_data, exp_line[a]);
      end
   endtask

   // Watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [LW-1:0] pa, pb, pc, pd;
      for (int i = 0; i < NA; i++) begin
         mline[i] = '0; mflg[i] = '0; smask[i] = '0; sval[i] = '0; exp_line[i] = '0;
      end
      for (int e = 0; e < CD; e++) begin
         cv[e] = 0; ca[e] = 0; cp[e] = 0; cs[e] = 0;
      end
      pa = {16{32'hA5A5_0F0F}};
      pb = {16{32'h1234_5678}};
      pc = {16{32'hC3C3_9999}};
      pd = {16{32'h0FF0_6666}};

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !wr_done && !wr_fail && !rd_valid && !mem_we && !mem_re,
          "R1", "outputs in reset", LW'({busy, wr_done, wr_fail, rd_valid, mem_we, mem_re}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !wr_done && !rd_valid, "R1", "outputs after reset",
          LW'({busy, wr_done, rd_valid}), '0);

      // R3: clean write, then read back
      do_write(0, pa, 0, 0, "R3");
      do_read(0);

      // R3: stuck cell already matching the data needs no rewrite
      smask[5][3] = 1'b1; sval[5][3] = pb[3];
      do_write(5, pb, 0, 0, "R3");
      do_read(5);

      // R4: one opposite stuck cell, rewrite with flag set
      smask[1][70] = 1'b1; sval[1][70] = ~pc[70];
      do_write(1, pc, 0, 0, "R4");
      do_read(1);

      // R5: cached fault honoured on the first attempt
      pd[70] = pc[70];
      do_write(1, pd, 0, 0, "R5");
      do_read(1);

      // R4: two faults in different partitions, two rewrites
      pb[130] = 1'b0; pb[400] = 1'b1;
      smask[2][130] = 1'b1; sval[2][130] = 1'b1;
      smask[2][400] = 1'b1; sval[2][400] = 1'b0;
      do_write(2, pb, 0, 0, "R4");
      do_read(2);

      // R6: three faults exceed the retry limit
      smask[3][5] = 1'b1;   sval[3][5]   = ~pa[5];
      smask[3][200] = 1'b1; sval[3][200] = ~pa[200];
      smask[3][300] = 1'b1; sval[3][300] = ~pa[300];
      do_write(3, pa, 0, 0, "R6");

      // R7: two faults inside one partition
      smask[4][10] = 1'b1; sval[4][10] = ~pc[10];
      smask[4][20] = 1'b1; sval[4][20] = ~pc[20];
      do_write(4, pc, 0, 0, "R7");

      // R7: new fault in a partition that holds a cached fault
      pd[130] = 1'b0; pd[140] = 1'b0;
      smask[2][140] = 1'b1; sval[2][140] = 1'b0;
      do_write(2, pd, 0, 0, "R7");

      // R8: the oldest entry (address 1) has been replaced, so a retry is needed again
      do_write(1, pc, 0, 0, "R8");
      do_read(1);

      // R10: requests while busy are ignored
      do_write(6, pa, 0, 1, "R10");
      do_read(6);

      // R10: write wins when both requests arrive together
      do_write(8, pb, 1, 0, "R10");
      do_read(8);

      // R11: write and read strobes never overlap
      chk(excl_bad == 0, "R11", "we/re overlap count", LW'(excl_bad), '0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule